// File: doc/BRIEF.md
# Memory Security Access Gate

This block stands between a CPU bus master and the on-chip RAM and flash arrays. It enforces a code-protection policy. Each bus access is judged by two things: where the instruction that is currently executing was fetched from, given on `exec_pc_i`, and the address it targets. While protection is engaged, code running outside the protected regions cannot see or change protected memory. Such reads return zero and such writes are dropped before they reach the array. Code running inside the protected regions keeps full access, and every access to unprotected space passes through unchanged.

The protection state and a key-enable flag are taken from nonvolatile option inputs on every clock while reset is asserted, so each restart reloads them. There are two ways to clear protection. Trusted code can stream an eight-byte key into a key port while key entry is enabled. Alternatively, the flash controller can report a completed mass erase. A parameter selects one of two variants. In the full variant, both RAM and flash are protected and a two-bit option field drives the state. In the reduced variant, only flash is protected, a single option bit drives the state, and only an erase can clear it.

Bus handshake rules: the master side (`m_*`) and the memory side (`s_*`) use valid/ready. A request that is allowed through is forwarded combinationally, so `s_valid_o` follows `m_valid_i` and `m_ready_o` follows `s_ready_i`. The memory's back-pressure therefore reaches the master directly, and read data is returned in the handshake cycle. A blocked request is never forwarded. The gate completes it itself in the same cycle, with `m_ready_o` high. The key port never applies back-pressure: `key_ready_o` is always 1, and each cycle with `key_valid_i` high offers one byte.

Top module: `mem_sec_gate`

## Requirements
- R1: On every clock with `rst_n` low, the protection state is loaded from `opt_sec_i`. In the full variant it is unprotected only when `opt_sec_i` is 2'b10, and protected for 2'b00, 2'b01 and 2'b11. In the reduced variant it is protected exactly when `opt_sec_i[0]` is 1. `secured_o` shows the state.
- R2: While protected, a read is blocked when it targets a protected address and `exec_pc_i` lies outside the protected regions. A blocked read returns `m_rdata_o` = 8'h00, raises `m_ready_o` and keeps `s_valid_o` low, all in the same cycle.
- R3: While protected, a write from the same kind of non-protected origin to a protected address is dropped. `s_valid_o` stays low and `m_ready_o` is 1 in that cycle.
- R4: Every access that is not blocked passes straight through. `s_valid_o`, `s_write_o`, `s_addr_o` and `s_wdata_o` copy the master request, `m_ready_o` copies `s_ready_i`, and `m_rdata_o` copies `s_rdata_i`.
- R5: In the full variant, the protected set is RAM (default 0x0080 to 0x107F) plus flash (default 0x1080 to 0xFFFF). In the reduced variant it is flash only. An origin counts as trusted when `exec_pc_i` lies in the protected set.
- R6: A key byte is taken only when all of these hold: `key_valid_i` is high, the block is protected, the key-enable option loaded at reset was 1, and `exec_pc_i` is trusted. Any other key byte is ignored and does not advance the key sequence.
- R7: Eight accepted bytes are compared in order. Byte i is compared with `opt_key_i[8i+7:8i]`, starting at i = 0. If all eight match, `secured_o` falls at the clock edge that takes the eighth byte.
- R8: An accepted byte that does not match locks key entry. From then on, further key bytes are ignored and protection stays on until the next reset or erase.
- R9: A one-cycle `erase_done_i` pulse clears protection at that clock edge, even when a key byte arrives in the same cycle.
- R10: In the reduced variant, the key port never clears protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; option inputs are loaded while low |
| opt_sec_i | input | 2 | Nonvolatile protection field |
| opt_keyen_i | input | 1 | Nonvolatile key-entry enable |
| opt_key_i | input | 64 | Stored key, byte 0 in bits 7:0 |
| erase_done_i | input | 1 | Mass erase completed pulse |
| exec_pc_i | input | 16 | Address of the instruction now executing |
| m_valid_i | input | 1 | Master request valid |
| m_ready_o | output | 1 | Master request accepted |
| m_write_i | input | 1 | Master request is a write |
| m_addr_i | input | 16 | Master address |
| m_wdata_i | input | 8 | Master write data |
| m_rdata_o | output | 8 | Read data to master |
| s_valid_o | output | 1 | Memory request valid |
| s_ready_i | input | 1 | Memory accepts request |
| s_write_o | output | 1 | Memory request is a write |
| s_addr_o | output | 16 | Memory address |
| s_wdata_o | output | 8 | Memory write data |
| s_rdata_i | input | 8 | Memory read data |
| key_valid_i | input | 1 | Key byte offered |
| key_ready_o | output | 1 | Key port ready, always 1 |
| key_data_i | input | 8 | Key byte |
| secured_o | output | 1 | Protection engaged |

## Verification
Some behaviour is checked by assertions on every cycle. A blocked read must return zero without reaching memory, and a blocked write must never be forwarded. While unprotected, master requests must pass through. Protection may only drop after an erase or a completed key match, and it must drop after an erase. A lockout must persist until an erase. Other behaviour only the bench scenarios can show. These are the option decoding at reset, the exact edge at which the eighth key byte unlocks, and that bytes offered from untrusted code or with key entry disabled leave the sequence untouched. They also cover the region boundaries and the reduced variant's refusal to unlock by key.

// File: rtl/sec_gate_pkg.sv
package sec_gate_pkg;

  typedef enum logic {
    VAR_FULL       = 1'b0,
    VAR_FLASH_ONLY = 1'b1
  } sec_variant_e;

  // Only this code of the two-bit field leaves the full variant open.
  localparam logic [1:0] SEC_OPEN_CODE = 2'b10;

  localparam int unsigned KEY_BYTE_W = 8;

endpackage

// File: rtl/sec_region_map.sv
module sec_region_map
  import sec_gate_pkg::*;
#(
  parameter int unsigned         ADDR_W   = 16,
  parameter sec_variant_e        VARIANT  = VAR_FULL,
  parameter logic [ADDR_W-1:0]   RAM_LO   = 16'h0080,
  parameter logic [ADDR_W-1:0]   RAM_HI   = 16'h107F,
  parameter logic [ADDR_W-1:0]   FLASH_LO = 16'h1080,
  parameter logic [ADDR_W-1:0]   FLASH_HI = 16'hFFFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);

  logic in_flash;
  assign in_flash = (addr_i >= FLASH_LO) && (addr_i <= FLASH_HI);

  generate
    if (VARIANT == VAR_FULL) begin : g_full
      logic in_ram;
      assign in_ram = (addr_i >= RAM_LO) && (addr_i <= RAM_HI);
      assign prot_o = in_ram || in_flash;
    end else begin : g_flash_only
      assign prot_o = in_flash;
    end
  endgenerate

endmodule

// File: rtl/sec_key_seq.sv
module sec_key_seq
  import sec_gate_pkg::*;
#(
  parameter sec_variant_e VARIANT   = VAR_FULL,
  parameter int unsigned  KEY_BYTES = 8,
  localparam int unsigned IDX_W     = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1,
  localparam int unsigned KEY_W     = KEY_BYTES * KEY_BYTE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  opt_keyen_i,
  input  logic [KEY_W-1:0]      opt_key_i,
  input  logic                  erase_i,
  input  logic                  secured_i,
  input  logic                  origin_trusted_i,
  input  logic                  key_valid_i,
  input  logic [KEY_BYTE_W-1:0] key_data_i,
  output logic                  unlock_o
);

  logic                  keyen_q;
  logic                  locked_q;
  logic [IDX_W-1:0]      idx_q;
  logic [KEY_BYTE_W-1:0] want_byte;
  logic                  take;
  logic                  hit;
  logic                  last;

  always_comb begin
    want_byte = '0;
    for (int b = 0; b < KEY_BYTES; b++) begin
      if (idx_q == IDX_W'(b)) want_byte = opt_key_i[b*KEY_BYTE_W +: KEY_BYTE_W];
    end
  end

  generate
    if (VARIANT == VAR_FULL) begin : g_key
      assign take = key_valid_i && secured_i && keyen_q && origin_trusted_i && !locked_q;
    end else begin : g_nokey
      assign take = 1'b0;
    end
  endgenerate

  assign hit      = (key_data_i == want_byte);
  assign last     = (idx_q == IDX_W'(KEY_BYTES - 1));
  assign unlock_o = take && hit && last && !erase_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keyen_q  <= opt_keyen_i;
      locked_q <= 1'b0;
      idx_q    <= '0;
    end else if (erase_i) begin
      locked_q <= 1'b0;
      idx_q    <= '0;
    end else if (take) begin
      if (!hit) begin
        locked_q <= 1'b1;
        idx_q    <= '0;
      end else if (last) begin
        idx_q    <= '0;
      end else begin
        idx_q    <= idx_q + IDX_W'(1);
      end
    end
  end

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !erase_i) |=> locked_q); // R8

  AST_NO_UNLOCK_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !secured_i |-> !unlock_o); // R6

  AST_NO_UNLOCK_UNTRUSTED: assert property (@(posedge clk) disable iff (!rst_n)
    !origin_trusted_i |-> !unlock_o); // R6

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(KEY_BYTES - 1)); // R7

endmodule

// File: rtl/sec_state.sv
module sec_state
  import sec_gate_pkg::*;
#(
  parameter sec_variant_e VARIANT = VAR_FULL
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] opt_sec_i,
  input  logic       erase_i,
  input  logic       unlock_i,
  output logic       secured_o
);

  logic load_val;
  logic secured_q;

  generate
    if (VARIANT == VAR_FULL) begin : g_two_bit
      assign load_val = (opt_sec_i != SEC_OPEN_CODE);
    end else begin : g_one_bit
      logic unused_hi;
      assign unused_hi = opt_sec_i[1];
      assign load_val  = opt_sec_i[0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      secured_q <= load_val;
    end else if (erase_i || unlock_i) begin
      secured_q <= 1'b0;
    end
  end

  assign secured_o = secured_q;

  AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    erase_i |=> !secured_q); // R9

  AST_DROP_ONLY_BY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(secured_q) |-> $past(erase_i || unlock_i)); // R7

endmodule

// File: rtl/mem_sec_gate.sv
module mem_sec_gate
  import sec_gate_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       KEY_BYTES = 8,
  parameter sec_variant_e      VARIANT   = VAR_FULL,
  parameter logic [ADDR_W-1:0] RAM_LO    = 16'h0080,
  parameter logic [ADDR_W-1:0] RAM_HI    = 16'h107F,
  parameter logic [ADDR_W-1:0] FLASH_LO  = 16'h1080,
  parameter logic [ADDR_W-1:0] FLASH_HI  = 16'hFFFF,
  localparam int unsigned      DATA_W    = KEY_BYTE_W,
  localparam int unsigned      KEY_W     = KEY_BYTES * KEY_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        opt_sec_i,
  input  logic              opt_keyen_i,
  input  logic [KEY_W-1:0]  opt_key_i,
  input  logic              erase_done_i,
  input  logic [ADDR_W-1:0] exec_pc_i,
  input  logic              m_valid_i,
  output logic              m_ready_o,
  input  logic              m_write_i,
  input  logic [ADDR_W-1:0] m_addr_i,
  input  logic [DATA_W-1:0] m_wdata_i,
  output logic [DATA_W-1:0] m_rdata_o,
  output logic              s_valid_o,
  input  logic              s_ready_i,
  output logic              s_write_o,
  output logic [ADDR_W-1:0] s_addr_o,
  output logic [DATA_W-1:0] s_wdata_o,
  input  logic [DATA_W-1:0] s_rdata_i,
  input  logic              key_valid_i,
  output logic              key_ready_o,
  input  logic [DATA_W-1:0] key_data_i,
  output logic              secured_o
);

  logic acc_prot;
  logic pc_prot;
  logic unlock;
  logic blocked;

  sec_region_map #(
    .ADDR_W(ADDR_W), .VARIANT(VARIANT),
    .RAM_LO(RAM_LO), .RAM_HI(RAM_HI), .FLASH_LO(FLASH_LO), .FLASH_HI(FLASH_HI)
  ) u_map_acc (
    .addr_i (m_addr_i),
    .prot_o (acc_prot)
  );

  sec_region_map #(
    .ADDR_W(ADDR_W), .VARIANT(VARIANT),
    .RAM_LO(RAM_LO), .RAM_HI(RAM_HI), .FLASH_LO(FLASH_LO), .FLASH_HI(FLASH_HI)
  ) u_map_pc (
    .addr_i (exec_pc_i),
    .prot_o (pc_prot)
  );

  sec_key_seq #(
    .VARIANT(VARIANT), .KEY_BYTES(KEY_BYTES)
  ) u_key (
    .clk              (clk),
    .rst_n            (rst_n),
    .opt_keyen_i      (opt_keyen_i),
    .opt_key_i        (opt_key_i),
    .erase_i          (erase_done_i),
    .secured_i        (secured_o),
    .origin_trusted_i (pc_prot),
    .key_valid_i      (key_valid_i),
    .key_data_i       (key_data_i),
    .unlock_o         (unlock)
  );

  sec_state #(
    .VARIANT(VARIANT)
  ) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .opt_sec_i (opt_sec_i),
    .erase_i   (erase_done_i),
    .unlock_i  (unlock),
    .secured_o (secured_o)
  );

  assign blocked     = secured_o && acc_prot && !pc_prot;
  assign s_valid_o   = m_valid_i && !blocked;
  assign s_write_o   = m_write_i;
  assign s_addr_o    = m_addr_i;
  assign s_wdata_o   = m_wdata_i;
  assign m_ready_o   = blocked ? 1'b1 : s_ready_i;
  assign m_rdata_o   = blocked ? '0 : s_rdata_i;
  assign key_ready_o = 1'b1;

  AST_BLOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (secured_o && m_valid_i && !m_write_i && acc_prot && !pc_prot)
      |-> (m_rdata_o == '0 && !s_valid_o && m_ready_o)); // R2

  AST_BLOCKED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (secured_o && m_valid_i && m_write_i && acc_prot && !pc_prot)
      |-> (!s_valid_o && m_ready_o)); // R3

  AST_OPEN_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (!secured_o && m_valid_i) |-> (s_valid_o && m_ready_o == s_ready_i)); // R4

endmodule

// File: tb/mem_sec_gate_bench.sv
`timescale 1ns/100ps
module mem_sec_gate_bench;
  import sec_gate_pkg::*;

  localparam logic [63:0] KEY = 64'h0123_4567_89AB_CDEF;
  localparam logic [15:0] PC_UNTR = 16'h0040;
  localparam logic [15:0] PC_FLASH = 16'h2000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [1:0]  opt_sec = 2'b00;
  logic        opt_keyen = 1'b1;
  logic        erase_done = 1'b0;
  logic [15:0] exec_pc = PC_UNTR;
  logic        m_valid = 1'b0, m_write = 1'b0, s_ready = 1'b1;
  logic [15:0] m_addr = '0;
  logic [7:0]  m_wdata = '0, s_rdata = '0;
  logic        key_valid = 1'b0;
  logic [7:0]  key_data = '0;

  logic        m_ready, s_valid, s_write, key_ready, secured;
  logic [15:0] s_addr;
  logic [7:0]  m_rdata, s_wdata;
  logic        f_m_ready, f_s_valid, f_s_write, f_key_ready, f_secured;
  logic [15:0] f_s_addr;
  logic [7:0]  f_m_rdata, f_s_wdata;

  mem_sec_gate u_mem_sec_gate (
    .clk(clk), .rst_n(rst_n), .opt_sec_i(opt_sec), .opt_keyen_i(opt_keyen),
    .opt_key_i(KEY), .erase_done_i(erase_done), .exec_pc_i(exec_pc),
    .m_valid_i(m_valid), .m_ready_o(m_ready), .m_write_i(m_write),
    .m_addr_i(m_addr), .m_wdata_i(m_wdata), .m_rdata_o(m_rdata),
    .s_valid_o(s_valid), .s_ready_i(s_ready), .s_write_o(s_write),
    .s_addr_o(s_addr), .s_wdata_o(s_wdata), .s_rdata_i(s_rdata),
    .key_valid_i(key_valid), .key_ready_o(key_ready), .key_data_i(key_data),
    .secured_o(secured)
  );

  mem_sec_gate #(.VARIANT(VAR_FLASH_ONLY)) u_mem_sec_gate_flash (
    .clk(clk), .rst_n(rst_n), .opt_sec_i(opt_sec), .opt_keyen_i(opt_keyen),
    .opt_key_i(KEY), .erase_done_i(erase_done), .exec_pc_i(exec_pc),
    .m_valid_i(m_valid), .m_ready_o(f_m_ready), .m_write_i(m_write),
    .m_addr_i(m_addr), .m_wdata_i(m_wdata), .m_rdata_o(f_m_rdata),
    .s_valid_o(f_s_valid), .s_ready_i(s_ready), .s_write_o(f_s_write),
    .s_addr_o(f_s_addr), .s_wdata_o(f_s_wdata), .s_rdata_i(s_rdata),
    .key_valid_i(key_valid), .key_ready_o(f_key_ready), .key_data_i(key_data),
    .secured_o(f_secured)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Row: req, wr, addr, pc, s_rdata, s_ready, exp s_valid, exp m_ready, exp m_rdata
  localparam int NROW = 11;
  localparam logic [55:0] ROWS [NROW] = '{
    {4'd2, 1'b0, 16'h0100, 16'h0040, 8'hA5, 1'b1, 1'b0, 1'b1, 8'h00}, // R2 RAM read untrusted
    {4'd2, 1'b0, 16'h2000, 16'h0040, 8'h77, 1'b0, 1'b0, 1'b1, 8'h00}, // R2 flash read, ready forced
    {4'd4, 1'b0, 16'h0010, 16'h0040, 8'h3C, 1'b1, 1'b1, 1'b1, 8'h3C}, // R4 unprotected IO
    {4'd5, 1'b0, 16'h0100, 16'h2000, 8'h5A, 1'b1, 1'b1, 1'b1, 8'h5A}, // R5 trusted origin
    {4'd3, 1'b1, 16'h0100, 16'h0040, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00}, // R3 dropped write
    {4'd4, 1'b1, 16'h0020, 16'h0040, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // R4 back-pressure
    {4'd5, 1'b1, 16'hFFFF, 16'h1080, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00}, // R5 flash low edge origin
    {4'd5, 1'b0, 16'h007F, 16'h0040, 8'h11, 1'b1, 1'b1, 1'b1, 8'h11}, // R5 just below RAM
    {4'd5, 1'b0, 16'h0080, 16'h0040, 8'h22, 1'b1, 1'b0, 1'b1, 8'h00}, // R5 first RAM byte
    {4'd5, 1'b0, 16'h1000, 16'h007F, 8'h33, 1'b1, 1'b0, 1'b1, 8'h00}, // R5 origin just outside
    {4'd5, 1'b0, 16'h1000, 16'h0080, 8'h44, 1'b1, 1'b1, 1'b1, 8'h44}  // R5 origin first RAM byte
  };

  task automatic do_reset(input logic [1:0] sec, input logic keyen);
    @(negedge clk);
    rst_n = 1'b0; opt_sec = sec; opt_keyen = keyen;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic key_byte(input logic [7:0] d, input logic [15:0] pc);
    @(negedge clk);
    key_valid = 1'b1; key_data = d; exec_pc = pc;
    @(negedge clk);
    key_valid = 1'b0;
    #1;
  endtask

  task automatic read_at(input logic [15:0] a, input logic [15:0] pc, input logic [7:0] rd);
    @(negedge clk);
    m_valid = 1'b1; m_write = 1'b0; m_addr = a; exec_pc = pc; s_rdata = rd; s_ready = 1'b1;
    #1;
  endtask

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset(2'b00, 1'b1);
    chk(secured === 1'b1, "R1 reset 00", 32'(secured), 1);
    chk(key_ready === 1'b1, "R6 key_ready", 32'(key_ready), 1);

    // Table walk while protected
    for (int i = 0; i < NROW; i++) begin
      logic [55:0] r;
      bit ok;
      r = ROWS[i];
      @(negedge clk);
      m_valid = 1'b1; m_write = r[51]; m_addr = r[50:35]; exec_pc = r[34:19];
      s_rdata = r[18:11]; s_ready = r[10]; m_wdata = 8'hC3;
      #1;
      ok = (s_valid === r[9]) && (m_ready === r[8]);
      if (r[9]) ok = ok && (s_addr === r[50:35]) && (s_write === r[51]) && (s_wdata === 8'hC3);
      if (!r[51]) ok = ok && (m_rdata === r[7:0]);
      chk(ok, $sformatf("R%0d row %0d", r[55:52], i),
          {14'd0, s_valid, m_ready, m_rdata, 8'd0}, {14'd0, r[9], r[8], r[7:0], 8'd0});
    end
    m_valid = 1'b0;

    // R1 codes
    do_reset(2'b10, 1'b1);
    chk(secured === 1'b0, "R1 code 10 open", 32'(secured), 0);
    read_at(16'h0100, PC_UNTR, 8'h6E);
    chk(s_valid === 1'b1 && m_rdata === 8'h6E, "R4 open read", 32'(m_rdata), 32'h6E);
    m_valid = 1'b0;
    do_reset(2'b01, 1'b1);
    chk(secured === 1'b1, "R1 code 01", 32'(secured), 1);
    do_reset(2'b11, 1'b1);
    chk(secured === 1'b1, "R1 code 11", 32'(secured), 1);

    // R6 untrusted bytes ignored, then full key
    for (int b = 0; b < 3; b++) key_byte(KEY[b*8 +: 8], PC_UNTR);
    chk(secured === 1'b1, "R6 untrusted bytes", 32'(secured), 1);
    for (int b = 0; b < 7; b++) key_byte(KEY[b*8 +: 8], PC_FLASH);
    chk(secured === 1'b1, "R7 seven bytes", 32'(secured), 1);
    key_byte(KEY[63:56], PC_FLASH);
    chk(secured === 1'b0, "R7 eighth byte unlocks", 32'(secured), 0);
    read_at(16'h0100, PC_UNTR, 8'h19);
    chk(m_rdata === 8'h19 && s_valid === 1'b1, "R7 unlocked read", 32'(m_rdata), 32'h19);
    m_valid = 1'b0;

    // R6 key enable off
    do_reset(2'b00, 1'b0);
    for (int b = 0; b < 8; b++) key_byte(KEY[b*8 +: 8], PC_FLASH);
    chk(secured === 1'b1, "R6 keyen off", 32'(secured), 1);

    // R8 mismatch locks
    do_reset(2'b00, 1'b1);
    key_byte(KEY[7:0], PC_FLASH);
    key_byte(8'h00, PC_FLASH);
    for (int b = 0; b < 8; b++) key_byte(KEY[b*8 +: 8], PC_FLASH);
    chk(secured === 1'b1, "R8 locked after mismatch", 32'(secured), 1);

    // R9 erase clears, then reset reloads
    @(negedge clk); erase_done = 1'b1; key_valid = 1'b1; key_data = 8'h00;
    @(negedge clk); erase_done = 1'b0; key_valid = 1'b0; #1;
    chk(secured === 1'b0, "R9 erase clears", 32'(secured), 0);
    do_reset(2'b00, 1'b1);
    chk(secured === 1'b1, "R1 reload after erase", 32'(secured), 1);

    // Reduced variant
    do_reset(2'b10, 1'b1);
    chk(f_secured === 1'b0, "R1 reduced bit0 0", 32'(f_secured), 0);
    do_reset(2'b01, 1'b1);
    chk(f_secured === 1'b1, "R1 reduced bit0 1", 32'(f_secured), 1);
    read_at(16'h0100, PC_UNTR, 8'h4D);
    chk(f_s_valid === 1'b1 && f_m_rdata === 8'h4D, "R5 reduced RAM open", 32'(f_m_rdata), 32'h4D);
    read_at(16'h2000, PC_UNTR, 8'h4D);
    chk(f_s_valid === 1'b0 && f_m_rdata === 8'h00, "R2 reduced flash blocked", 32'(f_m_rdata), 0);
    read_at(16'h3000, PC_FLASH, 8'h4E);
    chk(f_s_valid === 1'b1 && f_m_rdata === 8'h4E, "R5 reduced trusted", 32'(f_m_rdata), 32'h4E);
    m_valid = 1'b0;
    for (int b = 0; b < 8; b++) key_byte(KEY[b*8 +: 8], PC_FLASH);
    chk(f_secured === 1'b1, "R10 reduced key refused", 32'(f_secured), 1);
    chk(secured === 1'b0, "R7 full unlocks same key", 32'(secured), 0);
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0; #1;
    chk(f_secured === 1'b0, "R9 reduced erase", 32'(f_secured), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule